// File: doc/BRIEF.md
# Port LED Matrix Controller

This block lights two status LEDs for each copper port from three per-port inputs: link up, link speed and activity. A two-bit strap picks one of four display schemes. The strap is sampled while reset is held and frozen when reset releases. Three schemes use the LED pair as separate or bi-colour indicators. The fourth uses one LED per port and blinks it at a speed-dependent rate while traffic flows.

Activity pulses are stretched into a visible dark-then-lit interval, so a single frame still produces a blink. All lamps are time-multiplexed over a matrix of active-low row lines (one per port) and two column lines (one per LED). The column lines are also used by a serial-memory interface. When that interface raises a request, the scanner finishes its current row slot, turns every row off, releases the column lines and grants the bus. It resumes scanning on the next row once the request drops.

The scanner state machine has two states. In SCAN, a row is lit, and a slot end advances the row: back to SCAN when no request is pending, or on to GRANT when one is. In GRANT the bus is granted, and a dropped request returns the machine to SCAN. Each port's stretcher has three states. IDLE moves to DARK on activity. DARK moves to LIT after its half-interval. LIT moves to IDLE after its half-interval. A link loss forces IDLE.

Top module: `led_matrix_ctrl`

## Requirements
- R1: The display scheme is the value on `disp_strap` at the last rising clock edge with `rst_n` low. Strap changes after reset releases have no effect on the outputs.
- R2: Scheme 3, link up: column 0 is lit except during the dark half of an activity stretch. Column 1 is lit when the port runs at gigabit.
- R3: Scheme 2, link up: column 0 shows gigabit link and column 1 shows 10/100 link. Each goes dark during the dark half of an activity stretch.
- R4: Scheme 1 (bi-colour), link up, outside the dark half of an activity stretch: gigabit lights column 0 only, 100 Mb/s lights column 1 only, and 10 Mb/s lights both. During the dark half both are off.
- R5: Scheme 0, link up: column 1 stays off. Column 0 is steady on while no stretch is active. During a stretch it follows a free-running blink phase whose half-period is HALF_GIG, HALF_100 or HALF_10 ticks, and it is on after reset or link loss.
- R6: Speed code on `port_speed[2p+1:2p]`: bit 1 set means gigabit, 01 means 100 Mb/s, 00 means 10 Mb/s. Activity while a port is idle starts a stretch of ACT_HALF ticks dark followed by ACT_HALF ticks lit. Further activity during a stretch is absorbed. A tick occurs once every TICK_DIV clocks.
- R7: When a port's link is down, both its LEDs are off in every scheme, and its stretch and blink state return to idle.
- R8: While scanning, exactly one row line is low. Rows run 0, 1, 2 and repeat, each for SLOT_CYC clocks. Column bit c carries LED c of the selected port and `col_oe` is high. After reset, row 0 is selected.
- R9: A request seen at the end of a slot moves the scanner to grant. In grant, `ee_gnt` is high, all rows are high, `col_oe` is low and `col_out` is 0. The first clock with the request low returns it to scanning with a fresh slot on the following row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap sampled while low |
| disp_strap | input | 2 | Display scheme strap |
| port_link | input | NUM_PORTS | Link up per port |
| port_speed | input | 2*NUM_PORTS | Speed code per port, two bits each |
| port_act | input | NUM_PORTS | Activity indication per port |
| ee_req | input | 1 | Column-bus request from the serial-memory interface |
| ee_gnt | output | 1 | Column bus released to the serial-memory interface |
| row_n | output | NUM_PORTS | Active-low row (cathode) lines |
| col_out | output | 2 | Column (anode) data |
| col_oe | output | 1 | Column drive enable |

## Verification
Two functions can meet in one clock: the bus request can arrive in the very cycle a slot ends, and an activity pulse can land on the same clock as a prescaler tick. The bench repeats the request at every offset within a slot and mixes pseudo-random activity with link and speed changes, so both coincidences occur many times in each scheme. On every clock, a behavioural model built from the requirements predicts the row lines, the grant, the drive enable and the lit columns, and these are compared with the ports.

// File: rtl/led_pkg.sv
package led_pkg;
    typedef enum logic [1:0] {
        DISP_SINGLE  = 2'd0,
        DISP_BICOLOR = 2'd1,
        DISP_SPLIT   = 2'd2,
        DISP_LINKACT = 2'd3
    } disp_mode_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_DARK = 2'd1,
        ACT_LIT  = 2'd2
    } act_state_e;

    typedef enum logic {
        ST_SCAN  = 1'b0,
        ST_GRANT = 1'b1
    } scan_state_e;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/led_port_ctrl.sv
module led_port_ctrl
    import led_pkg::*;
#(
    parameter int HALF_GIG = 42,
    parameter int HALF_100 = 85,
    parameter int HALF_10  = 170,
    parameter int ACT_HALF = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  disp_mode_e mode,
    input  logic       link,
    input  logic [1:0] speed,
    input  logic       act,
    output logic [1:0] led
);
    localparam int MAXH = (HALF_GIG > HALF_100) ?
                          ((HALF_GIG > HALF_10) ? HALF_GIG : HALF_10) :
                          ((HALF_100 > HALF_10) ? HALF_100 : HALF_10);
    localparam int BW = $clog2(MAXH + 1);
    localparam int AW = $clog2(ACT_HALF + 1);

    act_state_e    act_st, act_nx;
    logic [AW-1:0] act_cnt, cnt_nx;
    logic [BW-1:0] bcnt, half_lim;
    logic          phase;
    logic          is_gig, is_100, is_10, lit, busy;

    assign is_gig = speed[1];
    assign is_100 = (speed == 2'b01);
    assign is_10  = (speed == 2'b00);

    // stretcher next state
    always_comb begin
        act_nx = act_st;
        cnt_nx = act_cnt;
        if (!link) begin
            act_nx = ACT_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (act_st)
                ACT_IDLE: begin
                    if (act) begin
                        act_nx = ACT_DARK;
                        cnt_nx = AW'(ACT_HALF);
                    end
                end
                ACT_DARK: begin
                    if (tick) begin
                        if (act_cnt == AW'(1)) begin
                            act_nx = ACT_LIT;
                            cnt_nx = AW'(ACT_HALF);
                        end else begin
                            cnt_nx = act_cnt - AW'(1);
                        end
                    end
                end
                ACT_LIT: begin
                    if (tick) begin
                        if (act_cnt == AW'(1)) begin
                            act_nx = ACT_IDLE;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = act_cnt - AW'(1);
                        end
                    end
                end
                default: begin
                    act_nx = ACT_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // stretcher state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_st  <= ACT_IDLE;
            act_cnt <= '0;
        end else begin
            act_st  <= act_nx;
            act_cnt <= cnt_nx;
        end
    end

    // speed-dependent blink phase
    always_comb begin
        if (is_gig)
            half_lim = BW'(HALF_GIG - 1);
        else if (is_100)
            half_lim = BW'(HALF_100 - 1);
        else
            half_lim = BW'(HALF_10 - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt  <= '0;
            phase <= 1'b1;
        end else if (!link) begin
            bcnt  <= '0;
            phase <= 1'b1;
        end else if (tick) begin
            if (bcnt >= half_lim) begin
                bcnt  <= '0;
                phase <= ~phase;
            end else begin
                bcnt <= bcnt + BW'(1);
            end
        end
    end

    // display decode
    assign lit  = (act_st != ACT_DARK);
    assign busy = (act_st != ACT_IDLE);

    always_comb begin
        led = 2'b00;
        if (link) begin
            unique case (mode)
                DISP_LINKACT: led = {is_gig, lit};
                DISP_SPLIT:   led = {~is_gig & lit, is_gig & lit};
                DISP_BICOLOR: led = {lit & (is_100 | is_10), lit & (is_gig | is_10)};
                DISP_SINGLE:  led = {1'b0, busy ? phase : 1'b1};
                default:      led = 2'b00;
            endcase
        end
    end
endmodule

// File: rtl/led_scan_fsm.sv
module led_scan_fsm
    import led_pkg::*;
#(
    parameter int ROWS     = 3,
    parameter int SLOT_CYC = 5000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ee_req,
    input  logic [ROWS-1:0][1:0]  led_mat,
    output logic                  ee_gnt,
    output logic [ROWS-1:0]       row_n,
    output logic [1:0]            col_out,
    output logic                  col_oe
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int SW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

    scan_state_e   st, st_nx;
    logic [RW-1:0] row, row_nx;
    logic [SW-1:0] slot_cnt, slot_nx;
    logic          slot_end;

    assign slot_end = (slot_cnt == SW'(SLOT_CYC - 1));

    always_comb begin
        st_nx   = st;
        row_nx  = row;
        slot_nx = slot_cnt;
        unique case (st)
            ST_SCAN: begin
                if (slot_end) begin
                    slot_nx = '0;
                    row_nx  = (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
                    if (ee_req)
                        st_nx = ST_GRANT;
                end else begin
                    slot_nx = slot_cnt + SW'(1);
                end
            end
            ST_GRANT: begin
                if (!ee_req)
                    st_nx = ST_SCAN;
            end
            default: st_nx = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_SCAN;
            row      <= '0;
            slot_cnt <= '0;
        end else begin
            st       <= st_nx;
            row      <= row_nx;
            slot_cnt <= slot_nx;
        end
    end

    always_comb begin
        unique case (st)
            ST_SCAN: begin
                ee_gnt  = 1'b0;
                row_n   = ~(ROWS'(1) << row);
                col_out = led_mat[row];
                col_oe  = 1'b1;
            end
            ST_GRANT: begin
                ee_gnt  = 1'b1;
                row_n   = '1;
                col_out = 2'b00;
                col_oe  = 1'b0;
            end
            default: begin
                ee_gnt  = 1'b0;
                row_n   = '1;
                col_out = 2'b00;
                col_oe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/led_matrix_ctrl.sv
module led_matrix_ctrl
    import led_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int TICK_DIV  = 50000,
    parameter int SLOT_CYC  = 5000,
    parameter int HALF_GIG  = 42,
    parameter int HALF_100  = 85,
    parameter int HALF_10   = 170,
    parameter int ACT_HALF  = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             disp_strap,
    input  logic [NUM_PORTS-1:0]   port_link,
    input  logic [2*NUM_PORTS-1:0] port_speed,
    input  logic [NUM_PORTS-1:0]   port_act,
    input  logic                   ee_req,
    output logic                   ee_gnt,
    output logic [NUM_PORTS-1:0]   row_n,
    output logic [1:0]             col_out,
    output logic                   col_oe
);
    disp_mode_e                mode_q;
    logic                      tick;
    logic [NUM_PORTS-1:0][1:0] led_mat;

    // strap capture: follows the pin while reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= disp_mode_e'(disp_strap);
    end

    led_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        led_port_ctrl #(
            .HALF_GIG (HALF_GIG),
            .HALF_100 (HALF_100),
            .HALF_10  (HALF_10),
            .ACT_HALF (ACT_HALF)
        ) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .mode  (mode_q),
            .link  (port_link[p]),
            .speed (port_speed[2*p +: 2]),
            .act   (port_act[p]),
            .led   (led_mat[p])
        );
    end

    led_scan_fsm #(
        .ROWS     (NUM_PORTS),
        .SLOT_CYC (SLOT_CYC)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ee_req  (ee_req),
        .led_mat (led_mat),
        .ee_gnt  (ee_gnt),
        .row_n   (row_n),
        .col_out (col_out),
        .col_oe  (col_oe)
    );
endmodule

// File: rtl/led_matrix_ctrl_chk.sv
module led_matrix_ctrl_chk #(
    parameter int NUM_PORTS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ee_req,
    input logic                 ee_gnt,
    input logic [NUM_PORTS-1:0] row_n,
    input logic [1:0]           col_out,
    input logic                 col_oe,
    input logic [NUM_PORTS-1:0] port_link,
    input logic [1:0]           mode_q
);
    assert_one_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_gnt |-> ($countones(~row_n) == 1 && col_oe));

    assert_bus_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ee_gnt |-> (row_n == '1 && !col_oe && col_out == 2'b00));

    assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_gnt) |-> $past(ee_req));

    assert_grant_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_gnt && ee_req) |=> ee_gnt);

    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    assert_single_led_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && !ee_gnt) |-> !col_out[1]);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_dark
        assert_link_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ee_gnt && !row_n[i] && !port_link[i]) |-> (col_out == 2'b00));
    end
endmodule

bind led_matrix_ctrl led_matrix_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ee_req    (ee_req),
    .ee_gnt    (ee_gnt),
    .row_n     (row_n),
    .col_out   (col_out),
    .col_oe    (col_oe),
    .port_link (port_link),
    .mode_q    (mode_q)
);

// File: tb/led_matrix_ctrl_test.sv
`timescale 1ns/1ps
module led_matrix_ctrl_test;
    localparam int NP = 3;
    localparam int TD = 3;
    localparam int SL = 4;
    localparam int HG = 2;
    localparam int H1 = 3;
    localparam int HT = 5;
    localparam int AH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    strap = 2'd3;
    logic [NP-1:0] link = '0;
    logic [2*NP-1:0] spd = '0;
    logic [NP-1:0] act = '0;
    logic          req = 1'b0;
    logic          gnt, oe;
    logic [NP-1:0] row_n;
    logic [1:0]    col;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    logic [31:0] lf = 32'hACE1_2468;

    always #10 clk = ~clk;

    led_matrix_ctrl #(
        .NUM_PORTS(NP), .TICK_DIV(TD), .SLOT_CYC(SL),
        .HALF_GIG(HG), .HALF_100(H1), .HALF_10(HT), .ACT_HALF(AH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .disp_strap(strap), .port_link(link),
        .port_speed(spd), .port_act(act), .ee_req(req), .ee_gnt(gnt),
        .row_n(row_n), .col_out(col), .col_oe(oe)
    );

    // behavioural reference state
    int m_mode, m_pcnt, m_scnt, m_row, m_st;
    int m_acn[NP];
    int m_bc[NP];
    int m_ph[NP];

    function automatic int half_of(int sp);
        if (sp >= 2) return HG;
        if (sp == 1) return H1;
        return HT;
    endfunction

    function automatic logic [1:0] exp_led(int p);
        int sp;
        logic lit, busy, g, s1, s0;
        sp = int'(spd[2*p +: 2]);
        if (!link[p]) return 2'b00;
        lit  = !(m_acn[p] > AH);
        busy = (m_acn[p] > 0);
        g  = (sp >= 2);
        s1 = (sp == 1);
        s0 = (sp == 0);
        case (m_mode)
            3: return {g, lit};
            2: return {!g & lit, g & lit};
            1: return {lit & (s1 | s0), lit & (g | s0)};
            default: return {1'b0, busy ? (m_ph[p] != 0) : 1'b1};
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mode = int'(strap);
            m_pcnt = 0; m_scnt = 0; m_row = 0; m_st = 0;
            for (int p = 0; p < NP; p++) begin
                m_acn[p] = 0; m_bc[p] = 0; m_ph[p] = 1;
            end
        end else begin
            bit tk;
            tk = (m_pcnt == TD - 1);
            m_pcnt = tk ? 0 : m_pcnt + 1;
            for (int p = 0; p < NP; p++) begin
                if (!link[p]) begin
                    m_acn[p] = 0; m_bc[p] = 0; m_ph[p] = 1;
                end else begin
                    if (act[p] && m_acn[p] == 0) m_acn[p] = 2 * AH;
                    else if (tk && m_acn[p] > 0) m_acn[p]--;
                    if (tk) begin
                        if (m_bc[p] >= half_of(int'(spd[2*p +: 2])) - 1) begin
                            m_bc[p] = 0; m_ph[p] = 1 - m_ph[p];
                        end else m_bc[p]++;
                    end
                end
            end
            if (m_st == 0) begin
                if (m_scnt == SL - 1) begin
                    m_scnt = 0;
                    m_row = (m_row == NP - 1) ? 0 : m_row + 1;
                    if (req) m_st = 1;
                end else m_scnt++;
            end else if (!req) m_st = 0;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NP-1:0] e_row;
            logic [1:0] e_col;
            logic e_oe, e_gnt;
            string tag;
            if (m_st == 0) begin
                e_row = ~(NP'(1) << m_row); e_oe = 1'b1; e_gnt = 1'b0;
                e_col = exp_led(m_row);
            end else begin
                e_row = '1; e_oe = 1'b0; e_gnt = 1'b1; e_col = 2'b00;
            end
            compared++;
            if (row_n !== e_row || oe !== e_oe || gnt !== e_gnt) begin
                mismatched++;
                $display("FAIL R8 R9 scan @%0d: row_n=%b oe=%b gnt=%b expected row_n=%b oe=%b gnt=%b",
                         cyc, row_n, oe, gnt, e_row, e_oe, e_gnt);
            end
            case (m_mode)
                3: tag = "R1 R2 R6 R7";
                2: tag = "R1 R3 R6 R7";
                1: tag = "R1 R4 R6 R7";
                default: tag = "R1 R5 R6 R7";
            endcase
            compared++;
            if (col !== e_col) begin
                mismatched++;
                $display("FAIL %s columns @%0d row %0d: got %b expected %b",
                         tag, cyc, m_row, col, e_col);
            end
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(int m, bit first);
        @(posedge clk); #1;
        rst_n = 1'b0; strap = 2'(m); link = '0; act = '0; req = 1'b0;
        run(3);
        rst_n = 1'b1;
        strap = ~2'(m);   // later strap changes must be ignored (R1)
        @(negedge clk);
        if (first) begin
            compared++;
            if (row_n !== 3'b110 || gnt !== 1'b0 || oe !== 1'b1 || col !== 2'b00) begin
                mismatched++;
                $display("FAIL R8 reset state: row_n=%b gnt=%b oe=%b col=%b expected 110 0 1 00",
                         row_n, gnt, oe, col);
            end
        end
        @(posedge clk); #1;
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    task automatic run_mode(int m, bit first);
        do_reset(m, first);
        // link down with activity: all dark (R7)
        for (int i = 0; i < 12; i++) begin act = 3'(i); run(1); end
        act = '0;
        link = 3'b111; spd = {2'b00, 2'b01, 2'b10};
        run(40);
        // single pulses per port (R6)
        act = 3'b001; run(1); act = '0; run(30);
        act = 3'b010; run(1); act = '0; run(30);
        act = 3'b111; run(40); act = '0;
        // speed change with pseudo-random traffic
        spd = {2'b10, 2'b00, 2'b01};
        for (int i = 0; i < 40; i++) begin step_lf(); act = lf[2:0] & {lf[5], 1'b1, lf[7]}; run(1); end
        act = '0;
        // grant request at every offset within a slot (R9)
        for (int off = 0; off <= SL; off++) begin
            run(off); req = 1'b1; act = 3'b101; run(9); req = 1'b0; act = '0; run(3);
        end
        // link drop in the middle of activity (R7)
        link = 3'b101; act = 3'b111; run(20);
        link = 3'b111; act = '0; run(20);
        spd = {2'b11, 2'b00, 2'b01};
        for (int i = 0; i < 150; i++) begin
            step_lf();
            act = lf[2:0];
            req = (lf[15:12] == 4'h0) ? 1'b1 : (req & lf[9]);
            if (lf[20:17] == 4'h3) link = lf[24:22] | 3'b001;
            run(1);
        end
        req = 1'b0; act = '0; run(10);
    endtask

    initial begin
        run_mode(3, 1'b1);
        run_mode(2, 1'b0);
        run_mode(1, 1'b0);
        run_mode(0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        mismatched++;
        $display("FAIL watchdog: run did not finish, cycle %0d expected below 100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule